// File: doc/BRIEF.md
# Power Mode Control State Machine

This block keeps track of the power mode a small system is in, and it is the only way into or out of the low-power modes. Software reaches it through a byte-wide register port. A write-once protection register states which families of low-power modes may ever be used. A mode control register holds the requested stop mode, the requested run mode and a wake-on-interrupt enable. A deep-stop register picks the submode of the deepest stop mode. A read-only one-hot status register shows the current mode.

Run-mode changes follow the run-mode field of the control register. The processor requests stop and wait modes with single-cycle pulses on `stop_req` and `sleep_req`. Each stop entry runs through a request cycle and then a commit cycle. An interrupt or a reset-abort that arrives in the request cycle cancels the entry and sets a sticky abort flag. The wake-up input, the interrupt input and the wake-on-interrupt bit decide where the system goes when it leaves a mode. A request that protection does not allow, and any reserved encoding, leaves the mode unchanged.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, register reads return 0x00 at address 0 (protection), 0x00 at address 1 (control), 0x03 at address 2 (deep-stop) and 0x01 at address 3 (status). `mode_status` is 0x01 and `stop_aborted` is 0. Read data is registered and is valid on the cycle after the read strobe is sampled.
- R2: Only the first protection write after reset takes effect. It stores the written bits 1 (allow very-low-leakage stop), 3 (allow low-leakage stop) and 5 (allow very-low-power modes), and all other bits read as zero. Every later protection write is ignored.
- R3: Control bits [2:0] select the stop mode: 000 normal stop (always accepted), 010 very-low-power stop (needs protection bit 5), 011 low-leakage stop (needs bit 3), 100 very-low-leakage stop (needs bit 1). A write with a disallowed or reserved (001, 101, 110, 111) value leaves the field unchanged.
- R4: Control bits [6:5] select the run mode: 00 normal run, 10 very-low-power run. Writing 10 is accepted only when protection bit 5 is set and the mode is normal run. A blocked request leaves the field reading 00. Reserved values (01, 11) are ignored. The mode follows the field one clock edge after the field changes.
- R5: `mode_status` and status register bits [6:0] are one-hot: bit0 normal run, bit1 normal stop, bit2 very-low-power run, bit3 very-low-power wait, bit4 very-low-power stop, bit5 low-leakage stop, bit6 very-low-leakage stop. A `stop_req` pulse in a run mode enters the selected stop mode on the second clock edge after the pulse is sampled. From very-low-power run, selection 000 enters very-low-power stop.
- R6: The abort flag (`stop_aborted`, control bit 3, read-only) clears on the edge that begins a stop entry. If `irq` or `abort_rst` is high in the request cycle, the stop mode is not entered, the mode stays as before and the flag is set.
- R7: An interrupt in normal stop returns to normal run. If very-low-power stop was entered from normal run, an interrupt always returns to normal run, whatever the wake-on-interrupt bit (control bit 7) holds.
- R8: In very-low-power run, in very-low-power wait, and in very-low-power stop entered from very-low-power run, an interrupt with control bit 7 = 1 returns to normal run and the run-mode field then reads 00. With bit 7 = 0 the system goes to, or stays in, very-low-power run.
- R9: A `sleep_req` pulse in very-low-power run enters very-low-power wait one edge later. In normal run it has no effect.
- R10: Low-leakage and very-low-leakage stop are left to normal run on `irq` or `wake_evt`. In every other mode `wake_evt` has no effect.
- R11: Deep-stop register bits [2:0] (submode 0 to 3) and bit 5 (brown-out detect disable) are writable, and the other bits read zero. A very-low-leakage stop entry with a reserved submode (4 to 7) is not taken: the mode is unchanged and no abort is flagged.
- R12: `bod_off` is high exactly while in very-low-leakage stop with submode 0 and deep-stop bit 5 set.
- R13: While `dbg_en` is high, the status does not move to normal stop or very-low-power stop (it keeps showing the mode before entry). The other modes still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 protection, 1 control, 2 deep-stop, 3 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| stop_req | input | 1 | Deep-sleep (stop) request pulse |
| sleep_req | input | 1 | Shallow sleep (wait) request pulse |
| irq | input | 1 | Pending interrupt |
| abort_rst | input | 1 | Reset event that aborts a stop entry |
| wake_evt | input | 1 | Wake-up event for the leakage stop modes |
| dbg_en | input | 1 | Debug active; hides entry into normal and very-low-power stop |
| mode_status | output | 7 | One-hot current mode |
| stop_aborted | output | 1 | Sticky flag: last stop entry was aborted |
| bod_off | output | 1 | Brown-out detect disabled in deepest submode |

## Verification
Every result is sampled at the falling edge after a counted number of rising edges. A register write is visible to a read strobe issued after it, with read data valid one edge after that strobe. A run-mode change shows on `mode_status` one edge after the control field updates, and a stop commit shows two edges after `stop_req` is sampled. The abort flag is checked both inside the request cycle, where it has just cleared, and one edge later, where it is set. Wakes are checked one edge after the sampled `irq` or `wake_evt`. Each ignored input is shown to have no effect by reading the mode or register it could have changed before the next stimulus is applied.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 2;
  localparam int NUM_MODES = 7;
  localparam int STOP_W    = 3;
  localparam int RUN_W     = 2;
  localparam int SUB_W     = 3;

  typedef logic [REG_W-1:0] reg_t;

  // mode value equals its status one-hot bit position; ENTRY is internal
  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_STOP  = 3'd1,
    M_VLPR  = 3'd2,
    M_VLPW  = 3'd3,
    M_VLPS  = 3'd4,
    M_LLS   = 3'd5,
    M_VLLS  = 3'd6,
    M_ENTRY = 3'd7
  } mode_e;

  localparam logic [ADDR_W-1:0] A_PROT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_DEEP = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam int P_VLLS_OK = 1;
  localparam int P_LLS_OK  = 3;
  localparam int P_VLP_OK  = 5;
  localparam reg_t PROT_MASK = reg_t'(8'h2A);

  localparam logic [STOP_W-1:0] SEL_STOP = 3'b000;
  localparam logic [STOP_W-1:0] SEL_VLPS = 3'b010;
  localparam logic [STOP_W-1:0] SEL_LLS  = 3'b011;
  localparam logic [STOP_W-1:0] SEL_VLLS = 3'b100;

  localparam logic [RUN_W-1:0] RUN_NORM = 2'b00;
  localparam logic [RUN_W-1:0] RUN_LOW  = 2'b10;

  localparam logic [SUB_W-1:0] SUB_RST  = 3'd3;
  localparam logic [SUB_W-1:0] SUB_MAX  = 3'd3;

  function automatic logic [NUM_MODES-1:0] mode_onehot(input mode_e m);
    return NUM_MODES'(1) << m;
  endfunction
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  reg_t                 wdata,
  output reg_t                 rdata,
  input  logic                 in_run,
  input  logic                 force_run,
  input  logic                 abort_flag,
  input  logic [NUM_MODES-1:0] status,
  output reg_t                 prot_q,
  output logic                 prot_locked,
  output logic [STOP_W-1:0]    stop_sel,
  output logic [RUN_W-1:0]     run_sel,
  output logic                 wake_en,
  output logic [SUB_W-1:0]     deep_sel,
  output logic                 bod_dis
);
  logic [STOP_W-1:0] w_stop;
  logic [RUN_W-1:0]  w_run;
  logic              stop_ok;
  logic              run_ok;
  logic [7:0]        rd_byte;

  assign w_stop = wdata[2:0];
  assign w_run  = wdata[6:5];

  always_comb begin
    case (w_stop)
      SEL_STOP: stop_ok = 1'b1;
      SEL_VLPS: stop_ok = prot_q[P_VLP_OK];
      SEL_LLS:  stop_ok = prot_q[P_LLS_OK];
      SEL_VLLS: stop_ok = prot_q[P_VLLS_OK];
      default:  stop_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (w_run == RUN_NORM)
      run_ok = 1'b1;
    else if (w_run == RUN_LOW)
      run_ok = prot_q[P_VLP_OK] && in_run;
    else
      run_ok = 1'b0;
  end

  always_comb begin
    case (addr)
      A_PROT:  rd_byte = prot_q[7:0];
      A_CTRL:  rd_byte = {wake_en, run_sel, 1'b0, abort_flag, stop_sel};
      A_DEEP:  rd_byte = {2'b00, bod_dis, 2'b00, deep_sel};
      default: rd_byte = {1'b0, status};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q      <= '0;
      prot_locked <= 1'b0;
      stop_sel    <= SEL_STOP;
      run_sel     <= RUN_NORM;
      wake_en     <= 1'b0;
      deep_sel    <= SUB_RST;
      bod_dis     <= 1'b0;
      rdata       <= '0;
    end else begin
      if (wr_en && addr == A_PROT && !prot_locked) begin
        prot_q      <= wdata & PROT_MASK;
        prot_locked <= 1'b1;
        stop_sel    <= SEL_STOP;
      end
      if (wr_en && addr == A_CTRL) begin
        if (stop_ok) stop_sel <= w_stop;
        if (run_ok)  run_sel  <= w_run;
        wake_en <= wdata[7];
      end
      if (force_run) run_sel <= RUN_NORM;
      if (wr_en && addr == A_DEEP) begin
        deep_sel <= wdata[SUB_W-1:0];
        bod_dis  <= wdata[5];
      end
      if (rd_en) rdata <= reg_t'(rd_byte);
    end
  end
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake
  import pmc_pkg::*;
(
  input  mode_e cur,
  input  logic  from_vlp,
  input  logic  wake_en,
  input  logic  irq,
  input  logic  wake_evt,
  output logic  wake,
  output mode_e dest
);
  always_comb begin
    wake = 1'b0;
    dest = M_RUN;
    case (cur)
      M_STOP: wake = irq;
      M_VLPS: begin
        wake = irq;
        dest = (from_vlp && !wake_en) ? M_VLPR : M_RUN;
      end
      M_VLPW: begin
        wake = irq;
        dest = wake_en ? M_RUN : M_VLPR;
      end
      M_VLPR: wake = irq && wake_en;
      M_LLS, M_VLLS: wake = irq || wake_evt;
      default: begin
        wake = 1'b0;
        dest = cur;
      end
    endcase
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_req,
  input  logic                 sleep_req,
  input  logic                 irq,
  input  logic                 abort_rst,
  input  logic                 wake_evt,
  input  logic                 dbg_en,
  input  logic [STOP_W-1:0]    stop_sel,
  input  logic [RUN_W-1:0]     run_sel,
  input  logic                 wake_en,
  input  logic [SUB_W-1:0]     deep_sel,
  input  logic                 bod_dis,
  output logic                 in_run,
  output logic                 force_run,
  output logic [NUM_MODES-1:0] status,
  output logic                 abort_flag,
  output logic                 bod_off
);
  mode_e state, nxt, origin, wake_dest;
  logic  wake_hit, set_abort, clr_abort, hide;

  pmc_wake u_wake (
    .cur      (state),
    .from_vlp (origin == M_VLPR),
    .wake_en  (wake_en),
    .irq      (irq),
    .wake_evt (wake_evt),
    .wake     (wake_hit),
    .dest     (wake_dest)
  );

  always_comb begin
    nxt       = state;
    set_abort = 1'b0;
    clr_abort = 1'b0;
    case (state)
      M_RUN: begin
        if (stop_req) begin
          nxt       = M_ENTRY;
          clr_abort = 1'b1;
        end else if (run_sel == RUN_LOW) begin
          nxt = M_VLPR;
        end
      end
      M_VLPR: begin
        if (wake_hit) begin
          nxt = wake_dest;
        end else if (stop_req) begin
          nxt       = M_ENTRY;
          clr_abort = 1'b1;
        end else if (sleep_req) begin
          nxt = M_VLPW;
        end else if (run_sel == RUN_NORM) begin
          nxt = M_RUN;
        end
      end
      M_ENTRY: begin
        if (irq || abort_rst) begin
          nxt       = origin;
          set_abort = 1'b1;
        end else begin
          case (stop_sel)
            SEL_STOP: nxt = (origin == M_VLPR) ? M_VLPS : M_STOP;
            SEL_VLPS: nxt = M_VLPS;
            SEL_LLS:  nxt = M_LLS;
            SEL_VLLS: nxt = (deep_sel <= SUB_MAX) ? M_VLLS : origin;
            default:  nxt = origin;
          endcase
        end
      end
      default: begin
        if (wake_hit) nxt = wake_dest;
      end
    endcase
  end

  assign force_run = (nxt == M_RUN) && (state != M_RUN);
  assign in_run    = (state == M_RUN);
  assign hide      = dbg_en && (nxt == M_STOP || nxt == M_VLPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= M_RUN;
      origin     <= M_RUN;
      status     <= mode_onehot(M_RUN);
      abort_flag <= 1'b0;
      bod_off    <= 1'b0;
    end else begin
      state <= nxt;
      if (state == M_RUN || state == M_VLPR) origin <= state;
      if (nxt != M_ENTRY && !hide) status <= mode_onehot(nxt);
      if (clr_abort) abort_flag <= 1'b0;
      else if (set_abort) abort_flag <= 1'b1;
      bod_off <= (nxt == M_VLLS) && (deep_sel == '0) && bod_dis;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 stop_req,
  input  logic                 sleep_req,
  input  logic                 irq,
  input  logic                 abort_rst,
  input  logic                 wake_evt,
  input  logic                 dbg_en,
  output logic [NUM_MODES-1:0] mode_status,
  output logic                 stop_aborted,
  output logic                 bod_off
);
  reg_t              prot_q;
  logic              prot_locked;
  logic [STOP_W-1:0] stop_sel;
  logic [RUN_W-1:0]  run_sel;
  logic              wake_en, bod_dis, in_run, force_run;
  logic [SUB_W-1:0]  deep_sel;

  pmc_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (reg_wr),
    .rd_en       (reg_rd),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .in_run      (in_run),
    .force_run   (force_run),
    .abort_flag  (stop_aborted),
    .status      (mode_status),
    .prot_q      (prot_q),
    .prot_locked (prot_locked),
    .stop_sel    (stop_sel),
    .run_sel     (run_sel),
    .wake_en     (wake_en),
    .deep_sel    (deep_sel),
    .bod_dis     (bod_dis)
  );

  pmc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stop_req   (stop_req),
    .sleep_req  (sleep_req),
    .irq        (irq),
    .abort_rst  (abort_rst),
    .wake_evt   (wake_evt),
    .dbg_en     (dbg_en),
    .stop_sel   (stop_sel),
    .run_sel    (run_sel),
    .wake_en    (wake_en),
    .deep_sel   (deep_sel),
    .bod_dis    (bod_dis),
    .in_run     (in_run),
    .force_run  (force_run),
    .status     (mode_status),
    .abort_flag (stop_aborted),
    .bod_off    (bod_off)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pmc_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_MODES-1:0] mode_status,
  input logic                 stop_aborted,
  input logic                 bod_off,
  input reg_t                 prot_q,
  input logic                 prot_locked
);
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_status) == 1); // R5
  AST_PROT_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (prot_q & ~PROT_MASK) == '0); // R2
  AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    prot_locked |=> $stable(prot_q)); // R2
  AST_ABORT_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_aborted) |-> $stable(mode_status)); // R6
  AST_VLPR_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_status[2]) |-> prot_q[P_VLP_OK]); // R4
  AST_LLS_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_status[5]) |-> prot_q[P_LLS_OK]); // R3
  AST_VLLS_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_status[6]) |-> prot_q[P_VLLS_OK]); // R3
  AST_BOD_ONLY_DEEPEST: assert property (@(posedge clk) disable iff (rst)
    bod_off |-> mode_status[6]); // R12
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_status  (mode_status),
  .stop_aborted (stop_aborted),
  .bod_off      (bod_off),
  .prot_q       (prot_q),
  .prot_locked  (prot_locked)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       stop_req = 0, sleep_req = 0, irq = 0, abort_rst = 0, wake_evt = 0, dbg_en = 0;
  logic [6:0] mode_status;
  logic       stop_aborted, bod_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_req(stop_req),
    .sleep_req(sleep_req), .irq(irq), .abort_rst(abort_rst), .wake_evt(wake_evt),
    .dbg_en(dbg_en), .mode_status(mode_status), .stop_aborted(stop_aborted),
    .bod_off(bod_off)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; stop_req = 0; sleep_req = 0; irq = 0; abort_rst = 0; wake_evt = 0; dbg_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // write sampled at one edge; returns at the following falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  // write control, then let the mode follow one more edge
  task automatic wr_ctrl(input logic [7:0] d);
    wr(2'd1, d);
    @(negedge clk);
  endtask

  task automatic pulse_stop_commit();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    @(negedge clk);
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1;
    @(negedge clk); irq = 0;
  endtask

  task automatic pulse_wake_evt();
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 status port", mode_status, 7'h01);
    chk("R1 abort port", stop_aborted, 0);
    rd(2'd0, d); chk("R1 prot reset", d, 8'h00);
    rd(2'd1, d); chk("R1 ctrl reset", d, 8'h00);
    rd(2'd2, d); chk("R1 deep reset", d, 8'h03);
    rd(2'd3, d); chk("R1 status reset", d, 8'h01);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 first write masked", d, 8'h2A);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R2 second write ignored", d, 8'h2A);
  endtask

  task automatic t_stop_filter();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h02);
    rd(2'd1, d); chk("R3 vlps blocked", d, 8'h00);
    wr(2'd1, 8'h03);
    rd(2'd1, d); chk("R3 lls accepted", d, 8'h03);
    wr(2'd1, 8'h04);
    rd(2'd1, d); chk("R3 vlls blocked", d, 8'h03);
    wr(2'd1, 8'h05);
    rd(2'd1, d); chk("R3 reserved ignored", d, 8'h03);
    pulse_stop_commit();
    chk("R5 lls entered", mode_status, 7'h20);
    pulse_irq();
    chk("R10 lls irq wake", mode_status, 7'h01);
  endtask

  task automatic t_vlpr();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h00);
    wr_ctrl(8'h40);
    rd(2'd1, d); chk("R4 blocked vlpr field", d, 8'h00);
    chk("R4 blocked vlpr mode", mode_status, 7'h01);
    do_reset();
    wr(2'd0, 8'h20);
    wr_ctrl(8'h20);
    rd(2'd1, d); chk("R4 reserved run ignored", d, 8'h00);
    wr_ctrl(8'h40);
    chk("R4 vlpr entered", mode_status, 7'h04);
    rd(2'd1, d); chk("R4 vlpr field", d, 8'h40);
    wr_ctrl(8'h00);
    chk("R4 back to run", mode_status, 7'h01);
  endtask

  task automatic t_stop_run();
    do_reset();
    wr(2'd0, 8'h2A);
    wr(2'd1, 8'h00);
    pulse_stop_commit();
    chk("R5 normal stop", mode_status, 7'h02);
    pulse_wake_evt();
    chk("R10 wake_evt ignored in stop", mode_status, 7'h02);
    pulse_irq();
    chk("R7 stop irq wake", mode_status, 7'h01);
    wr(2'd1, 8'h02);
    pulse_stop_commit();
    chk("R5 vlps from run", mode_status, 7'h10);
    pulse_irq();
    chk("R7 vlps direct wake to run", mode_status, 7'h01);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h2A);
    wr(2'd1, 8'h03);
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0; irq = 1;
    @(negedge clk); irq = 0;
    chk("R6 irq abort mode", mode_status, 7'h01);
    chk("R6 irq abort flag", stop_aborted, 1);
    rd(2'd1, d); chk("R6 ctrl abort bit", d, 8'h0B);
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0; abort_rst = 1;
    chk("R6 flag cleared at entry", stop_aborted, 0);
    @(negedge clk); abort_rst = 0;
    chk("R6 reset abort flag", stop_aborted, 1);
    chk("R6 reset abort mode", mode_status, 7'h01);
    pulse_stop_commit();
    chk("R6 clean entry lls", mode_status, 7'h20);
    chk("R6 clean entry flag", stop_aborted, 0);
  endtask

  task automatic t_vlp_wake();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h2A);
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    @(negedge clk);
    chk("R9 sleep in run ignored", mode_status, 7'h01);
    wr_ctrl(8'h40);
    chk("R8 vlpr", mode_status, 7'h04);
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    chk("R9 vlpw entered", mode_status, 7'h08);
    pulse_irq();
    chk("R8 vlpw to vlpr", mode_status, 7'h04);
    pulse_irq();
    chk("R8 vlpr stays", mode_status, 7'h04);
    pulse_stop_commit();
    chk("R5 vlps from vlpr", mode_status, 7'h10);
    pulse_irq();
    chk("R8 vlps to vlpr", mode_status, 7'h04);
    wr(2'd1, 8'hC0);
    pulse_irq();
    chk("R8 wake to run", mode_status, 7'h01);
    rd(2'd1, d); chk("R8 run field cleared", d, 8'h80);
  endtask

  task automatic t_deep();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h2A);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R11 deep mask", d, 8'h27);
    wr(2'd1, 8'h04);
    pulse_stop_commit();
    chk("R11 reserved submode blocked", mode_status, 7'h01);
    chk("R11 no abort", stop_aborted, 0);
    wr(2'd2, 8'h20);
    pulse_stop_commit();
    chk("R5 vlls entered", mode_status, 7'h40);
    chk("R12 bod off", bod_off, 1);
    pulse_wake_evt();
    chk("R10 vlls wake_evt", mode_status, 7'h01);
    chk("R12 bod back on", bod_off, 0);
  endtask

  task automatic t_debug();
    do_reset();
    wr(2'd0, 8'h2A);
    dbg_en = 1;
    wr(2'd1, 8'h00);
    pulse_stop_commit();
    chk("R13 stop hidden", mode_status, 7'h01);
    pulse_irq();
    wr(2'd1, 8'h02);
    pulse_stop_commit();
    chk("R13 vlps hidden", mode_status, 7'h01);
    pulse_irq();
    wr(2'd1, 8'h03);
    pulse_stop_commit();
    chk("R13 lls still shown", mode_status, 7'h20);
    pulse_irq();
    chk("R13 run after wake", mode_status, 7'h01);
    dbg_en = 0;
  endtask

  initial begin
    t_reset();
    t_protect();
    t_stop_filter();
    t_vlpr();
    t_stop_run();
    t_abort();
    t_vlp_wake();
    t_deep();
    t_debug();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule